// File: doc/BRIEF.md
# Chip-Select Bus Wait Sequencer

This block runs the external memory bus for a 16-bit CPU with four chip-select windows. A CPU request is decoded against four fixed address windows. A hit starts an external cycle. The cycle has an address phase with the latch enable high, then a strobe phase of programmable length, then a one-cycle acknowledge. An address that misses every window is treated as internal. For an internal access the external pins are parked in a defined idle state while the CPU gets its acknowledge.

Each window has two pieces of configuration:
- A no-wait bit. When it is set, the strobe phase is a single cycle and the ready input is ignored.
- A 2-bit stretch code. It sets one to three wait cycles, and the ready input can hold the final wait.

Software changes both through a small write port. The port enforces the order in which they may be reprogrammed, and it raises an error pulse for an illegal or reserved setting.

Top module: `cs_wait_ctrl`

## Requirements
- R1: After reset, all no-wait bits and stretch codes are 0, every chip select is high, read/write strobes are high, latch enable is low, ack is low and the error flag is low.
- R2: With a window's no-wait bit at 0 and ready high, stretch codes 00, 01 and 10 give 1, 2 and 3 wait cycles. The ack then appears 4, 5 or 6 cycles after the clock edge that accepts the request.
- R3: With the no-wait bit at 1, the strobe phase lasts one cycle and the ready input is ignored. The ack appears 3 cycles after acceptance.
- R4: With the no-wait bit at 0, the final wait repeats while ready is low. The cycle ends on the first edge where both the programmed waits have elapsed and ready is high.
- R5: A stretch-register write (reg_sel_i=1, window i in bits [2i+1:2i]) leaves a field unchanged when that window's no-wait bit is 1 and the new value differs. Such a write pulses reg_err_o for one cycle.
- R6: A no-wait write (reg_sel_i=0, window i in bit i) cannot set a bit from 0 to 1 while that window's stretch code is not 00. The bit stays 0 and reg_err_o pulses. Clearing a bit is always accepted.
- R7: Code 11 is accepted into the field, behaves as 3 waits, and pulses reg_err_o.
- R8: In an external cycle, only the selected window's chip select is low, from the address phase through the strobe phase. The latch enable is high only in the address phase.
- R9: In the strobe phase a read drives bus_rd_no low. A write drives bus_wr_no low, bus_wrl_no low if be_i[0], bus_wrh_no low if be_i[1], and the data bus with the write data. bus_bhe_no is the inverse of be_i[1].
- R10: An internal access to the SFR area (address below SFR_SIZE) drives the address, byte-high enable and strobes as an external cycle would. All chip selects stay high and the latch enable stays low. The data bus carries the write data on writes and is released on reads.
- R11: An internal access to any other address keeps the address and byte-high enable at their last values. Strobes and chip selects are high and the latch enable is low.
- R12: An internal access acks 2 cycles after acceptance.
- R13: ack_o is a single-cycle pulse. On an external read, rdata_o holds the bus data sampled on the last strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Configuration write strobe |
| reg_sel_i | input | 1 | 0: no-wait bits, 1: stretch codes |
| reg_wdata_i | input | 8 | Configuration write data |
| reg_err_o | output | 1 | One-cycle pulse on a rejected or reserved write |
| req_i | input | 1 | CPU access request, held until ack |
| we_i | input | 1 | 1 = write |
| addr_i | input | 20 | CPU address |
| be_i | input | 2 | Byte enables, bit 1 = high byte |
| wdata_i | input | 16 | CPU write data |
| ack_o | output | 1 | Access complete |
| rdata_o | output | 16 | Read data from the external bus |
| rdy_i | input | 1 | External ready |
| bus_addr_o | output | 20 | External address |
| bus_data_o | output | 16 | External data out |
| bus_data_oe_o | output | 1 | Data bus drive enable |
| bus_data_i | input | 16 | External data in |
| bus_rd_no | output | 1 | Read strobe, active low |
| bus_wr_no | output | 1 | Write strobe, active low |
| bus_wrl_no | output | 1 | Low-byte write strobe, active low |
| bus_wrh_no | output | 1 | High-byte write strobe, active low |
| bus_bhe_no | output | 1 | Byte-high enable, active low |
| bus_cs_no | output | 4 | Chip selects, active low |
| bus_ale_o | output | 1 | Address latch enable |

## Verification
Some properties are checked by assertions on every cycle:
- at most one chip select is low, and read and write strobes are never low together;
- pins are parked during internal cycles;
- a no-wait strobe phase ends after exactly one cycle;
- ack is a single-cycle pulse;
- a no-wait bit only rises over a zero stretch code, and a locked field never changes.

Other behaviour only the bench scenarios can show: the exact ack latency for each stretch code and ready pattern, the error pulse for each write, the strobe and data values per byte enable, and the address and byte-high enable held across ROM/RAM accesses.

// File: rtl/cs_wait_pkg.sv
package cs_wait_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_STRB, ST_INT, ST_DONE} seq_state_t;

  // no-wait -> 0; code 00/01/10 -> 1/2/3; reserved 11 -> 3
  function automatic logic [1:0] wait_count(input logic nowait, input logic [1:0] code);
    if (nowait) return 2'd0;
    if (code == 2'b11) return 2'd3;
    return code + 2'd1;
  endfunction
endpackage

// File: rtl/cs_wait_regs.sv
module cs_wait_regs #(
  parameter int NUM_CS = 4,
  localparam int REG_W = 2 * NUM_CS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [NUM_CS-1:0] nowait_o,
  output logic [REG_W-1:0]  exp_o,
  output logic              err_o
);
  logic [NUM_CS-1:0] nowait_q, nowait_d;
  logic [REG_W-1:0]  exp_q, exp_d;
  logic              err_q, err_d;

  always_comb begin
    nowait_d = nowait_q;
    exp_d    = exp_q;
    err_d    = 1'b0;
    if (we_i) begin
      if (!sel_i) begin
        for (int i = 0; i < NUM_CS; i++) begin
          if (wdata_i[i] && !nowait_q[i] && exp_q[2*i +: 2] != 2'b00) err_d = 1'b1;
          else nowait_d[i] = wdata_i[i];
        end
      end else begin
        for (int i = 0; i < NUM_CS; i++) begin
          if (nowait_q[i]) begin
            if (wdata_i[2*i +: 2] != exp_q[2*i +: 2]) err_d = 1'b1;
          end else begin
            exp_d[2*i +: 2] = wdata_i[2*i +: 2];
            if (wdata_i[2*i +: 2] == 2'b11) err_d = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nowait_q <= '0;
      exp_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      nowait_q <= nowait_d;
      exp_q    <= exp_d;
      err_q    <= err_d;
    end
  end

  assign nowait_o = nowait_q;
  assign exp_o    = exp_q;
  assign err_o    = err_q;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_chk
    assert_nowait_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (nowait_q[g] && !$past(nowait_q[g])) |-> ($past(exp_q[2*g +: 2]) == 2'b00));
    assert_exp_locked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exp_q[2*g +: 2] != $past(exp_q[2*g +: 2])) |-> !$past(nowait_q[g]));
  end
endmodule

// File: rtl/cs_wait_decode.sv
module cs_wait_decode #(
  parameter int ADDR_W = 20,
  parameter int NUM_CS = 4,
  parameter int SPAN_LOG2 = 16,
  parameter logic [NUM_CS*ADDR_W-1:0] CS_BASE = {20'h40000, 20'h30000, 20'h20000, 20'h10000},
  parameter logic [ADDR_W-1:0] SFR_SIZE = 20'h00400,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  region_o,
  output logic              sfr_o
);
  logic [NUM_CS-1:0] win_hit;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_win
    assign win_hit[g] = addr_i[ADDR_W-1:SPAN_LOG2] == CS_BASE[g*ADDR_W+SPAN_LOG2 +: ADDR_W-SPAN_LOG2];
  end

  // lowest window index wins on overlap
  always_comb begin
    region_o = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (win_hit[i]) region_o = IDX_W'(i);
    end
  end

  assign hit_o = |win_hit;
  assign sfr_o = !hit_o && (addr_i < SFR_SIZE);
endmodule

// File: rtl/cs_wait_seq.sv
module cs_wait_seq
  import cs_wait_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int NUM_CS = 4,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BE_W-1:0]     be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                hit_i,
  input  logic [IDX_W-1:0]    region_i,
  input  logic                sfr_i,
  input  logic [NUM_CS-1:0]   nowait_i,
  input  logic [2*NUM_CS-1:0] exp_i,
  input  logic                rdy_i,
  input  logic [DATA_W-1:0]   bus_data_i,
  output logic                ack_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [ADDR_W-1:0]   bus_addr_o,
  output logic [DATA_W-1:0]   bus_data_o,
  output logic                bus_data_oe_o,
  output logic                bus_rd_no,
  output logic                bus_wr_no,
  output logic                bus_wrl_no,
  output logic                bus_wrh_no,
  output logic                bus_bhe_no,
  output logic [NUM_CS-1:0]   bus_cs_no,
  output logic                bus_ale_o
);
  seq_state_t        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              bhe_q, we_q, sfr_q, nw_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [IDX_W-1:0]  region_q;
  logic [1:0]        waits_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      bhe_q    <= 1'b1;
      we_q     <= 1'b0;
      sfr_q    <= 1'b0;
      nw_q     <= 1'b0;
      be_q     <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      region_q <= '0;
      waits_q  <= '0;
      cnt_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_i) begin
          we_q    <= we_i;
          be_q    <= be_i;
          wdata_q <= wdata_i;
          sfr_q   <= sfr_i;
          if (hit_i || sfr_i) begin
            addr_q <= addr_i;
            bhe_q  <= !be_i[BE_W-1];
          end
          if (hit_i) begin
            region_q <= region_i;
            nw_q     <= nowait_i[region_i];
            waits_q  <= wait_count(nowait_i[region_i], exp_i[2*region_i +: 2]);
            state_q  <= ST_ADDR;
          end else begin
            state_q  <= ST_INT;
          end
        end
        ST_ADDR: begin
          cnt_q   <= '0;
          state_q <= ST_STRB;
        end
        ST_STRB: begin
          if (cnt_q == waits_q && (nw_q || rdy_i)) begin
            rdata_q <= bus_data_i;
            state_q <= ST_DONE;
          end else if (cnt_q != waits_q) begin
            cnt_q <= cnt_q + 2'd1;
          end
        end
        ST_INT:  state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic strobe_on;
  assign strobe_on = (state_q == ST_STRB) || (state_q == ST_INT && sfr_q);

  always_comb begin
    bus_cs_no = '1;
    if (state_q == ST_ADDR || state_q == ST_STRB) bus_cs_no[region_q] = 1'b0;
  end

  assign bus_ale_o     = (state_q == ST_ADDR);
  assign bus_addr_o    = addr_q;
  assign bus_bhe_no    = bhe_q;
  assign bus_rd_no     = !(strobe_on && !we_q);
  assign bus_wr_no     = !(strobe_on && we_q);
  assign bus_wrl_no    = !(strobe_on && we_q && be_q[0]);
  assign bus_wrh_no    = !(strobe_on && we_q && be_q[BE_W-1]);
  assign bus_data_oe_o = we_q && (state_q == ST_STRB || state_q == ST_INT);
  // ROM/RAM write: value on the bus is don't-care, zero chosen
  assign bus_data_o    = (state_q == ST_INT && !sfr_q) ? '0 : wdata_q;
  assign ack_o         = (state_q == ST_DONE);
  assign rdata_o       = rdata_q;

  assert_cs_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~bus_cs_no));
  assert_strobe_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!bus_rd_no && !bus_wr_no));
  assert_int_park_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INT) |-> (&bus_cs_no && !bus_ale_o));
  assert_rom_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INT && !sfr_q) |-> (bus_rd_no && bus_wr_no && $stable(bus_addr_o) && $stable(bus_bhe_no)));
  assert_nowait_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STRB && nw_q) |=> (state_q == ST_DONE));
  assert_ack_pulse_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
endmodule

// File: rtl/cs_wait_ctrl.sv
module cs_wait_ctrl #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int NUM_CS = 4,
  parameter int SPAN_LOG2 = 16,
  parameter logic [NUM_CS*ADDR_W-1:0] CS_BASE = {20'h40000, 20'h30000, 20'h20000, 20'h10000},
  parameter logic [ADDR_W-1:0] SFR_SIZE = 20'h00400,
  localparam int REG_W = 2 * NUM_CS,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic              reg_err_o,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rdy_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe_o,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              bus_rd_no,
  output logic              bus_wr_no,
  output logic              bus_wrl_no,
  output logic              bus_wrh_no,
  output logic              bus_bhe_no,
  output logic [NUM_CS-1:0] bus_cs_no,
  output logic              bus_ale_o
);
  logic [NUM_CS-1:0] nowait;
  logic [REG_W-1:0]  exp_code;
  logic              hit, sfr;
  logic [IDX_W-1:0]  region;

  cs_wait_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .nowait_o(nowait), .exp_o(exp_code), .err_o(reg_err_o)
  );

  cs_wait_decode #(
    .ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .SPAN_LOG2(SPAN_LOG2),
    .CS_BASE(CS_BASE), .SFR_SIZE(SFR_SIZE)
  ) u_dec (
    .addr_i, .hit_o(hit), .region_o(region), .sfr_o(sfr)
  );

  cs_wait_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS)) u_seq (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .be_i, .wdata_i,
    .hit_i(hit), .region_i(region), .sfr_i(sfr),
    .nowait_i(nowait), .exp_i(exp_code), .rdy_i, .bus_data_i,
    .ack_o, .rdata_o, .bus_addr_o, .bus_data_o, .bus_data_oe_o,
    .bus_rd_no, .bus_wr_no, .bus_wrl_no, .bus_wrh_no, .bus_bhe_no,
    .bus_cs_no, .bus_ale_o
  );
endmodule

// File: tb/cs_wait_ctrl_tb_top.sv
`timescale 1ns/1ps
module cs_wait_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0, reg_sel = 0, reg_err;
  logic [7:0] reg_wdata = 0;
  logic req = 0, we = 0, ack, rdy = 1;
  logic [19:0] addr = 0, bus_addr;
  logic [1:0] be = 0;
  logic [15:0] wdata = 0, rdata, bus_dout, bus_din = 0;
  logic bus_oe, rd_n, wr_n, wrl_n, wrh_n, bhe_n, ale;
  logic [3:0] cs_n;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [3:0] m_nw = 0;
  logic [7:0] m_exp = 0;
  logic [19:0] m_addr = 0;
  logic m_bhe = 1;

  always #2 clk = ~clk;

  cs_wait_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_err_o(reg_err), .req_i(req), .we_i(we),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata),
    .rdy_i(rdy), .bus_addr_o(bus_addr), .bus_data_o(bus_dout), .bus_data_oe_o(bus_oe),
    .bus_data_i(bus_din), .bus_rd_no(rd_n), .bus_wr_no(wr_n), .bus_wrl_no(wrl_n),
    .bus_wrh_no(wrh_n), .bus_bhe_no(bhe_n), .bus_cs_no(cs_n), .bus_ale_o(ale)
  );

  task automatic check(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  function automatic int waits_of(input int r);
    logic [1:0] c;
    c = m_exp[2*r +: 2];
    if (m_nw[r]) return 0;
    return (c == 2'b11) ? 3 : int'(c) + 1;
  endfunction

  // R5 R6 R7: model of accepted fields and error pulse
  task automatic reg_write(input bit sel, input logic [7:0] d);
    bit e = 0;
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    if (!sel) begin
      for (int i = 0; i < 4; i++) begin
        if (d[i] && !m_nw[i] && m_exp[2*i +: 2] != 0) e = 1;
        else m_nw[i] = d[i];
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (m_nw[i]) begin
          if (d[2*i +: 2] != m_exp[2*i +: 2]) e = 1;
        end else begin
          m_exp[2*i +: 2] = d[2*i +: 2];
          if (d[2*i +: 2] == 2'b11) e = 1;
        end
      end
    end
    @(negedge clk);
    reg_we = 0;
    check(reg_err == e, sel ? "R5/R7 err" : "R6 err", reg_err, e);
  endtask

  // rel: negedge index at which rdy rises (0 = high throughout)
  task automatic access(input bit w, input logic [19:0] a, input logic [1:0] b, input int rel);
    int region, n, lat;
    bit ext, sfr;
    logic [15:0] d, din;
    d = 16'($urandom); din = 16'($urandom);
    region = int'(a >> 16) - 1;
    ext = (region >= 0 && region < 4);
    sfr = !ext && (a < 20'h400);
    if (ext) lat = m_nw[region] ? 3 : ((3 + waits_of(region) > rel + 1) ? 3 + waits_of(region) : rel + 1);
    else lat = 2;
    @(negedge clk);
    req = 1; we = w; addr = a; be = b; wdata = d; bus_din = din; rdy = (rel == 0);
    n = 0;
    while (!ack && n < 40) begin
      @(negedge clk);
      n++;
      if (n == 1 && ext) begin
        check(cs_n == ~(4'b1 << region) && ale == 1 && bus_addr == a, "R8 addr phase", {cs_n, 3'b0, ale, bus_addr}, {~(4'b1 << region), 4'b1, a});
      end
      if (n == 2 && ext) begin
        check(rd_n == w && wr_n == !w && wrl_n == !(w && b[0]) && wrh_n == !(w && b[1]) && bhe_n == !b[1] && ale == 0,
              "R9 strobes", {rd_n, wr_n, wrl_n, wrh_n, bhe_n, ale}, {w, !w, !(w && b[0]), !(w && b[1]), !b[1], 1'b0});
        if (w) check(bus_oe && bus_dout == d, "R9 write data", {bus_oe, bus_dout}, {1'b1, d});
      end
      if (n == 1 && !ext) begin
        check(cs_n == 4'hF && ale == 0, "R10/R11 park", {cs_n, ale}, {4'hF, 1'b0});
        if (sfr) begin
          check(bus_addr == a && rd_n == w && wr_n == !w && bhe_n == !b[1] && bus_oe == w,
                "R10 sfr pins", {bus_addr, rd_n, wr_n, bhe_n, bus_oe}, {a, w, !w, !b[1], w});
          if (w) check(bus_dout == d, "R10 sfr data", bus_dout, d);
        end else begin
          check(bus_addr == m_addr && bhe_n == m_bhe && rd_n && wr_n && wrl_n && wrh_n,
                "R11 hold", {bus_addr, bhe_n, rd_n, wr_n}, {m_addr, m_bhe, 2'b11});
        end
      end
      if (n == rel) rdy = 1;
    end
    check(n == lat, ext ? (m_nw[region] ? "R3 latency" : (rel > 0 ? "R4 latency" : "R2 latency")) : "R12 latency", n, lat);
    if (ext && !w) check(rdata == din, "R13 rdata", rdata, din);
    req = 0; rdy = 1;
    @(negedge clk);
    check(!ack, "R13 ack pulse", ack, 0);
    if (ext || sfr) begin m_addr = a; m_bhe = !b[1]; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(cs_n == 4'hF && rd_n && wr_n && !ale && !ack && !reg_err, "R1 reset pins",
          {cs_n, rd_n, wr_n, ale, ack, reg_err}, {4'hF, 2'b11, 3'b000});
    rst_n = 1;
    access(0, 20'h10010, 2'b11, 0);                 // R2 code 00
    reg_write(1, 8'b11_10_01_00);                   // R7 reserved in window 3
    for (int r = 0; r < 4; r++) access(r[0], 20'h10000 * (r + 1) + 20'h44, 2'b01, 0);
    access(0, 20'h20000, 2'b11, 7);                 // R4 rdy stretch
    reg_write(0, 8'h02);                            // R6 reject: window 1 code 01
    reg_write(0, 8'h01);                            // window 0 code 00: accepted
    access(0, 20'h10000, 2'b10, 6);                 // R3 rdy ignored
    reg_write(1, 8'b11_10_01_01);                   // R5 reject window 0 change
    access(1, 20'h00100, 2'b10, 0);                 // R10 sfr write
    access(0, 20'h00200, 2'b01, 0);                 // R10 sfr read
    access(1, 20'h80000, 2'b11, 0);                 // R11 rom/ram
    reg_write(0, 8'h00);
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(0, 3) == 0) begin
        reg_write(1'($urandom), 8'($urandom));
      end else begin
        int sel;
        logic [19:0] a;
        logic [1:0] b;
        sel = $urandom_range(0, 5);
        if (sel < 4) a = 20'h10000 * (sel + 1) + 20'($urandom_range(0, 16'hFFFF));
        else if (sel == 4) a = 20'($urandom_range(0, 20'h3FF));
        else a = 20'h90000 + 20'($urandom_range(0, 20'hFFFF));
        b = 2'($urandom_range(1, 3));
        access(1'($urandom), a, b, ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(2, 8));
      end
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule